// File: doc/BRIEF.md
# I2C Serial Byte-Memory Target Interface

This block is the bus-facing front end of a small serial byte memory that sits on a two-wire I2C bus as a target. It oversamples the SCL and SDA lines with the system clock and recognises START and STOP conditions. It compares the incoming device address with a fixed type code and three strap inputs. It acknowledges the address and every written byte. On reads it shifts out data and watches the master's acknowledge. The open-drain SDA output is modelled as a single drive-low enable. The bus-level SDA, with the pull-up and every driver combined, is fed back on `sdaIn`.

Behind the bus logic, a word address pointer selects locations in a byte array of 2^ADDR_W entries (8K by default). The array sits beside the block and is reached through a plain port. The port has an address, a one-cycle write strobe with data, and read data that is returned one clock after the address. A write transfer carries two pointer bytes and then any number of data bytes. A read transfer streams bytes from the current pointer. A repeated START between the two gives a random read.

Top module: `i2cMemTarget`

## Requirements
- R1: After reset, and until a START (SDA falling while SCL is high) is seen, the target never pulls SDA low and never writes the array, whatever SCL and SDA do.
- R2: An address byte, received MSB first after a START, whose bits 7..4 are 1010 and whose bits 3..1 equal `strap[2:0]` is acknowledged: SDA is held low through the ninth SCL clock. Bit 0 selects the direction (1 = read, 0 = write).
- R3: An address byte that differs in the type code or the strap bits gets no acknowledge, and the bytes that follow it are not acknowledged either.
- R4: In the write direction every received byte is acknowledged. The first byte sets pointer bits 12..8 from its bits 4..0, with bits 7..5 ignored. The second byte sets pointer bits 7..0.
- R5: Each later write byte produces exactly one one-cycle `memWrEn` pulse, with `memAddr` equal to the pointer and `memWrData` equal to the byte. The pointer then increments and wraps from 0x1FFF to 0x0000.
- R6: In the read direction the target sends, MSB first, the byte stored at the current pointer. The pointer increments after each byte, so a read without pointer bytes continues where the last transfer left off.
- R7: When the master acknowledges a read byte (SDA low on the ninth clock), the next byte follows. On a not-acknowledge the target leaves SDA released for all further clocks until a STOP.
- R8: A STOP (SDA rising while SCL is high) returns the target to idle at any point. A partly received byte is discarded and the pointer is left unchanged.
- R9: A START seen in the middle of a transfer restarts address matching without a STOP in between.
- R10: The drive-low enable changes only while SCL is low, after a detected SCL falling edge.
- R11: `memRdData` is taken as valid from the clock after `memAddr` settles. The target samples it only at SCL falling edges that begin a read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level, including this target's own drive |
| strap | input | 3 | Chip-select strap pins compared with address bits 3..1 |
| sdaDriveLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| memAddr | output | ADDR_W | Word address pointer presented to the array |
| memWrEn | output | 1 | One-cycle array write strobe |
| memWrData | output | 8 | Byte written to the array |
| memRdData | input | 8 | Array byte at `memAddr`, one clock of latency |

## Verification
A wrong control state shows up at SDA within one bit time. The target then acknowledges where it should stay silent, stays silent where it should acknowledge, or drives read bits after a not-acknowledge. A corrupted pointer or shift register is seen at the array port on the next data byte, through a write strobe to the wrong address or with the wrong data, or in the first read bit that differs from the reference byte. A lost STOP or repeated START is exposed by the next address byte's acknowledge slot.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT_STOP
  } busState_t;

  // events and decoded values from the datapath
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic byteDone;
    logic addrMatch;
    logic rwBit;
    logic sdaIn;
    logic txNextBit;
    logic rdMsb;
  } busEvt_t;

  // strobes from control to the datapath
  typedef struct packed {
    logic clrBit;
    logic cntBit;
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic ldPtrHi;
    logic ldPtrLo;
    logic incPtr;
    logic wrMem;
  } dpCtl_t;

endpackage

// File: rtl/i2cMemDatapath.sv
module i2cMemDatapath
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strap,
  input  dpCtl_t            ctl,
  output busEvt_t           evt,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData
);

  localparam int HI_W = ADDR_W - 8;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclQ, sdaQ, sclPrev, sdaPrev;
  logic [7:0] shReg;
  logic [3:0] bitCnt;
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclQ;
      sdaPrev <= sdaQ;
    end
  end

  assign sclQ = sclPipe[SYNC_STAGES-1];
  assign sdaQ = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
      ptr    <= '0;
    end else begin
      if (ctl.shiftIn)      shReg <= {shReg[6:0], sdaQ};
      else if (ctl.loadTx)  shReg <= memRdData;
      else if (ctl.shiftTx) shReg <= {shReg[6:0], 1'b0};

      if (ctl.clrBit)      bitCnt <= '0;
      else if (ctl.cntBit) bitCnt <= bitCnt + 4'd1;

      if (ctl.ldPtrHi)      ptr[ADDR_W-1:8] <= shReg[HI_W-1:0];
      else if (ctl.ldPtrLo) ptr[7:0] <= shReg;
      else if (ctl.incPtr)  ptr <= ptr + 1'b1;
    end
  end

  always_comb begin
    evt.start     = sclQ & sclPrev & sdaPrev & ~sdaQ;
    evt.stop      = sclQ & sclPrev & ~sdaPrev & sdaQ;
    evt.sclRise   = sclQ & ~sclPrev;
    evt.sclFall   = ~sclQ & sclPrev;
    evt.byteDone  = (bitCnt == 4'd8);
    evt.addrMatch = (shReg[7:1] == {DEV_TYPE, strap});
    evt.rwBit     = shReg[0];
    evt.sdaIn     = sdaQ;
    evt.txNextBit = shReg[6];
    evt.rdMsb     = memRdData[7];
  end

  assign memAddr   = ptr;
  assign memWrEn   = ctl.wrMem;
  assign memWrData = shReg;

endmodule

// File: rtl/i2cMemCtrl.sv
module i2cMemCtrl
  import i2c_mem_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t evt,
  output dpCtl_t  ctl,
  output logic    sdaDriveLow
);

  busState_t st, stNxt;
  logic lowNxt, rwReg, rwNxt, ackSeen, ackNxt;
  logic [1:0] byteIdx, idxNxt;

  always_comb begin
    ctl    = '0;
    stNxt  = st;
    lowNxt = sdaDriveLow;
    rwNxt  = rwReg;
    ackNxt = ackSeen;
    idxNxt = byteIdx;
    if (evt.stop) begin
      stNxt  = ST_IDLE;
      lowNxt = 1'b0;
    end else if (evt.start) begin
      stNxt      = ST_ADDR;
      lowNxt     = 1'b0;
      ctl.clrBit = 1'b1;
    end else begin
      unique case (st)
        ST_ADDR: begin
          if (evt.sclRise) begin
            ctl.shiftIn = 1'b1;
            ctl.cntBit  = 1'b1;
          end else if (evt.sclFall && evt.byteDone) begin
            if (evt.addrMatch) begin
              lowNxt = 1'b1;
              rwNxt  = evt.rwBit;
              stNxt  = ST_ADDR_ACK;
            end else begin
              stNxt = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (evt.sclFall) begin
            ctl.clrBit = 1'b1;
            if (rwReg) begin
              ctl.loadTx = 1'b1;
              lowNxt     = ~evt.rdMsb;
              stNxt      = ST_TX;
            end else begin
              lowNxt = 1'b0;
              idxNxt = 2'd0;
              stNxt  = ST_RX;
            end
          end
        end
        ST_RX: begin
          if (evt.sclRise) begin
            ctl.shiftIn = 1'b1;
            ctl.cntBit  = 1'b1;
          end else if (evt.sclFall && evt.byteDone) begin
            lowNxt = 1'b1;
            stNxt  = ST_RX_ACK;
            case (byteIdx)
              2'd0: begin
                ctl.ldPtrHi = 1'b1;
                idxNxt      = 2'd1;
              end
              2'd1: begin
                ctl.ldPtrLo = 1'b1;
                idxNxt      = 2'd2;
              end
              default: begin
                ctl.wrMem  = 1'b1;
                ctl.incPtr = 1'b1;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (evt.sclFall) begin
            lowNxt     = 1'b0;
            ctl.clrBit = 1'b1;
            stNxt      = ST_RX;
          end
        end
        ST_TX: begin
          if (evt.sclRise) begin
            ctl.cntBit = 1'b1;
          end else if (evt.sclFall) begin
            if (evt.byteDone) begin
              lowNxt     = 1'b0;
              ctl.clrBit = 1'b1;
              stNxt      = ST_MACK;
            end else begin
              ctl.shiftTx = 1'b1;
              lowNxt      = ~evt.txNextBit;
            end
          end
        end
        ST_MACK: begin
          if (evt.sclRise) begin
            ctl.incPtr = 1'b1;
            ackNxt     = ~evt.sdaIn;
          end else if (evt.sclFall) begin
            if (ackSeen) begin
              ctl.loadTx = 1'b1;
              lowNxt     = ~evt.rdMsb;
              stNxt      = ST_TX;
            end else begin
              stNxt = ST_WAIT_STOP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st          <= ST_IDLE;
      sdaDriveLow <= 1'b0;
      rwReg       <= 1'b0;
      ackSeen     <= 1'b0;
      byteIdx     <= 2'd0;
    end else begin
      st          <= stNxt;
      sdaDriveLow <= lowNxt;
      rwReg       <= rwNxt;
      ackSeen     <= ackNxt;
      byteIdx     <= idxNxt;
    end
  end

endmodule

// File: rtl/i2cMemTarget.sv
module i2cMemTarget
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strap,
  output logic              sdaDriveLow,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData
);

  busEvt_t evt;
  dpCtl_t  ctl;

  i2cMemDatapath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .ctl(ctl), .evt(evt), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .memRdData(memRdData)
  );

  i2cMemCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .evt(evt), .ctl(ctl), .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: rtl/i2cMemTarget_chk.sv
module i2cMemTarget_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaDriveLow,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWrEn
);

  // R10: the open-drain enable moves only while SCL is low
  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn);

  // R5: a write strobe lasts one cycle
  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

  // R5: the pointer advances by one after each write, wrapping
  p_wr_advance_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> (memAddr == $past(memAddr) + {{(ADDR_W-1){1'b0}}, 1'b1}));

  // R4: every stored byte is acknowledged
  p_wr_acked_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> sdaDriveLow);

endmodule

bind i2cMemTarget i2cMemTarget_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .memAddr(memAddr), .memWrEn(memWrEn)
);

// File: tb/i2cMemTarget_tb.sv
module i2cMemTarget_tb_top;

  localparam int ADDR_W = 13;
  localparam int Q      = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sdaDriveLow, memWrEn;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0] memWrData;
  logic [7:0] memRdData = 8'h00;
  wire sdaBus = mSda & ~sdaDriveLow;

  int total = 0;
  int bad = 0;
  logic prevLow = 1'b0;
  int expA[$];
  int expD[$];
  int popA, popD;
  logic [7:0] mem [int];

  always #10 clk = ~clk;

  i2cMemTarget #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .strap(strap),
    .sdaDriveLow(sdaDriveLow), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrData(memWrData), .memRdData(memRdData)
  );

  function automatic logic [7:0] memVal(int a);
    if (mem.exists(a)) return mem[a];
    return ~a[7:0];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // array model: R11 one clock of read latency
  always @(posedge clk) begin
    memRdData <= memVal(int'(memAddr));
    if (memWrEn) mem[int'(memAddr)] = memWrData;
  end

  // per-clock comparison with the reference write stream and drive timing
  always @(negedge clk) begin
    if (rstN) begin
      if (memWrEn) begin
        if (expA.size() == 0) begin
          check(1'b0, "R8 unexpected write", int'(memAddr), 0);
        end else begin
          popA = expA.pop_front();
          popD = expD.pop_front();
          check(int'(memAddr) == popA && int'(memWrData) == popD, "R5 write",
                int'({memAddr, memWrData}), (popA << 8) | popD);
        end
      end
      if (sdaDriveLow != prevLow && scl)
        check(1'b0, "R10 drive changed with SCL high", int'(sdaDriveLow), int'(prevLow));
    end
    prevLow = sdaDriveLow;
  end

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; q(); scl = 1'b1; q(); mSda = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic busStop();
    mSda = 1'b0; q(); scl = 1'b1; q(); mSda = 1'b1; q();
  endtask

  task automatic clockBit(input bit b, output bit seen);
    mSda = b; q(); scl = 1'b1; q(); seen = sdaBus; q(); scl = 1'b0; q();
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    bit s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    check((!s) == expAck, req, int'(!s), int'(expAck));
  endtask

  task automatic recvByte(input logic [7:0] exp, input bit mAck, input string req);
    bit s;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      v[i] = s;
    end
    check(v == exp, req, int'(v), int'(exp));
    clockBit(!mAck, s);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    bit s;
    repeat (5) @(negedge clk);
    check(sdaDriveLow == 1'b0, "R1 reset drive", int'(sdaDriveLow), 0);
    check(memWrEn == 1'b0, "R1 reset write", int'(memWrEn), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: a matching address without START draws no acknowledge
    scl = 1'b0; q();
    sendByte(8'hAA, 1'b0, "R1 no START");
    sendByte(8'h00, 1'b0, "R1 no START data");
    mSda = 1'b1; q(); scl = 1'b1; q();

    // R2 R4 R5: write with pointer wrap
    busStart();
    sendByte(8'hAA, 1'b1, "R2 address ack");
    sendByte(8'hFF, 1'b1, "R4 pointer high ack");
    sendByte(8'hFE, 1'b1, "R4 pointer low ack");
    expA.push_back(32'h1FFE); expD.push_back(32'h11);
    expA.push_back(32'h1FFF); expD.push_back(32'h22);
    expA.push_back(32'h0000); expD.push_back(32'h33);
    sendByte(8'h11, 1'b1, "R4 data ack");
    sendByte(8'h22, 1'b1, "R4 data ack");
    sendByte(8'h33, 1'b1, "R5 wrap data ack");
    busStop();
    q();
    check(expA.size() == 0, "R5 writes done", expA.size(), 0);

    // R3: strap and type mismatches
    busStart();
    sendByte(8'hA8, 1'b0, "R3 strap mismatch");
    sendByte(8'h55, 1'b0, "R3 later byte");
    busStop();
    busStart();
    sendByte(8'h2A, 1'b0, "R3 type mismatch");
    busStop();

    // R9 R6 R7: random read through repeated START
    busStart();
    sendByte(8'hAA, 1'b1, "R9 write address");
    sendByte(8'h1F, 1'b1, "R9 pointer high");
    sendByte(8'hFE, 1'b1, "R9 pointer low");
    busStart();
    sendByte(8'hAB, 1'b1, "R9 read address after repeated START");
    recvByte(8'h11, 1'b1, "R6 read byte 1FFE");
    recvByte(8'h22, 1'b1, "R7 acked continuation");
    recvByte(8'h33, 1'b0, "R7 wrapped byte");
    recvByte(8'hFF, 1'b0, "R7 released after not-acknowledge");
    busStop();

    // R6: current-pointer read continues at 0x0001
    busStart();
    sendByte(8'hAB, 1'b1, "R6 read address");
    recvByte(memVal(1), 1'b0, "R6 current pointer");
    busStop();

    // R8: STOP inside a data byte discards it
    busStart();
    sendByte(8'hAA, 1'b1, "R8 address");
    sendByte(8'h00, 1'b1, "R8 pointer high");
    sendByte(8'h10, 1'b1, "R8 pointer low");
    for (int i = 0; i < 4; i++) clockBit(i[0], s);
    busStop();
    q();
    busStart();
    sendByte(8'hAB, 1'b1, "R8 read address");
    recvByte(memVal(32'h10), 1'b0, "R8 pointer kept after STOP");
    busStop();
    check(expA.size() == 0, "R8 no pending write", expA.size(), 0);

    q();
    finishRun();
  end

endmodule